// File: doc/BRIEF.md
# Activity Monitor Counter Bank

A per-core bank of 64-bit event counters used by system-management software to observe how busy a core is. Four fixed counters have set event sources: core clock cycles, a constant-rate time base, retired instructions, and stall cycles caused by last-level cache misses. Beside them sits a parameterised group of auxiliary counters, up to sixteen, each driven by its own event strobe. Nothing counts while the core sits in either low-power wait state.

Software reaches the bank through a simple request port. Each request carries a write flag, a 6-bit address and the current privilege level. The same port saves counters before power-down and restores them afterwards. It also sets the two enable masks and the user-access bit. Counters whose enable bit is clear read back as zero. An access from the least privileged level that is not allowed raises a trap pulse and returns no data.

Address map: bits [5:4] select the space (0 = fixed counters, 1 = auxiliary counters, 2 = control, 3 = reserved and reads zero), and bits [3:0] select the slot. The control slots are: 0 = fixed enable mask (bit k enables fixed counter k), 1 = auxiliary enable mask (bit k enables auxiliary counter k), 2 = user-access bit (bit 0).

Top module: `act_mon_bank`

## Requirements
- R1: After reset every counter, both enable masks and the user-access bit are zero, and rvalid_o and trap_o are low.
- R2: When its enable bit is set, fixed counter 0 adds one every clock. Fixed counter 1 adds one on each cycle with tick_i high, counter 2 on each cycle with retire_i high, and counter 3 on each cycle with stall_i high.
- R3: Auxiliary counter k adds one on each cycle with aux_evt_i[k] high, provided auxiliary enable bit k is set.
- R4: While wfi_i or wfe_i is high, no counter changes except through a register write.
- R5: A counter whose enable bit is clear does not count and reads as zero. It keeps its value, accepts writes, and shows that value again once it is re-enabled.
- R6: A granted read (req_i high, we_i low) returns data on rdata_o with rvalid_o high in the following cycle. The data is the value held before that cycle's clock edge.
- R7: Fixed slots 4 to 15, auxiliary slots at or above N_AUX, unused control slots and the reserved space all read as zero. Writes to them have no effect.
- R8: A request with priv_i equal to 0 traps when the user-access bit is clear, and always traps when it targets the control space. A trapped request pulses trap_o in the next cycle, gives no rvalid_o, and changes no counter or control bit.
- R9: A granted write loads wdata_i into the addressed counter at the clock edge. If that counter's event fires in the same cycle, the event is dropped.
- R10: A counter holding all ones wraps to zero on its next event, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Constant-rate time base tick |
| retire_i | input | 1 | Instruction retired strobe |
| stall_i | input | 1 | Cache-miss dispatch stall strobe |
| aux_evt_i | input | N_AUX | Auxiliary event strobes |
| wfi_i | input | 1 | Core waiting for interrupt |
| wfe_i | input | 1 | Core waiting for event |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Request is a write |
| addr_i | input | 6 | Space [5:4] and slot [3:0] |
| wdata_i | input | CNT_W | Write data |
| priv_i | input | 2 | Privilege level of the request, 0 lowest |
| rdata_o | output | CNT_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after request |
| trap_o | output | 1 | Access trap pulse, one cycle after request |

## Verification
Two things can hit the same counter in one cycle: a restore write through the register port and that counter's own event strobe. The bench provokes this by writing fixed counter 2 while retire_i is high, and auxiliary counter 0 while its strobe is high. It then reads each counter back with the strobe low, so the write must win and the event must leave no trace. A read issued while the same counter is counting is also compared against the model value from before that edge.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam int NUM_FIX = 4;
  localparam int SLOT_W  = 4;
  localparam int ADDR_W  = 2 + SLOT_W;

  typedef enum logic [1:0] {
    SP_FIX  = 2'd0,
    SP_AUX  = 2'd1,
    SP_CTL  = 2'd2,
    SP_RSVD = 2'd3
  } space_e;

  localparam logic [SLOT_W-1:0] CTL_FEN = 4'd0;
  localparam logic [SLOT_W-1:0] CTL_AEN = 4'd1;
  localparam logic [SLOT_W-1:0] CTL_USR = 4'd2;
  localparam int NUM_CTL = 3;
endpackage

// File: rtl/act_mon_counter.sv
module act_mon_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;          // restore wins over event
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1); // silent wrap
  end
endmodule

// File: rtl/act_mon_access.sv
module act_mon_access
  import act_mon_pkg::*;
#(
  parameter int N_AUX = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        priv_i,
  input  logic              user_en_i,
  output logic              trap_now_o,
  output logic              rd_go_o,
  output logic [NUM_FIX-1:0] fix_wr_o,
  output logic [N_AUX-1:0]  aux_wr_o,
  output logic [NUM_CTL-1:0] ctl_wr_o
);
  space_e            space;
  logic [SLOT_W-1:0] idx;
  logic              go, wr_go;

  assign space = space_e'(addr_i[ADDR_W-1:SLOT_W]);
  assign idx   = addr_i[SLOT_W-1:0];

  assign trap_now_o = req_i && (priv_i == 2'd0) && (!user_en_i || space == SP_CTL);
  assign go         = req_i && !trap_now_o;
  assign rd_go_o    = go && !we_i;
  assign wr_go      = go && we_i;

  for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix_dec
    assign fix_wr_o[g] = wr_go && space == SP_FIX && idx == SLOT_W'(g);
  end
  for (genvar g = 0; g < N_AUX; g++) begin : g_aux_dec
    assign aux_wr_o[g] = wr_go && space == SP_AUX && idx == SLOT_W'(g);
  end
  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl_dec
    assign ctl_wr_o[g] = wr_go && space == SP_CTL && idx == SLOT_W'(g);
  end
endmodule

// File: rtl/act_mon_rdmux.sv
module act_mon_rdmux
  import act_mon_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int N_AUX = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_go_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_FIX-1:0][CNT_W-1:0]  fix_i,
  input  logic [N_AUX-1:0][CNT_W-1:0]    aux_i,
  input  logic [NUM_FIX-1:0]             fen_i,
  input  logic [N_AUX-1:0]               aen_i,
  input  logic                           uen_i,
  output logic [CNT_W-1:0]               rdata_o,
  output logic                           rvalid_o
);
  space_e            space;
  logic [SLOT_W-1:0] idx;
  logic [CNT_W-1:0]  sel;

  assign space = space_e'(addr_i[ADDR_W-1:SLOT_W]);
  assign idx   = addr_i[SLOT_W-1:0];

  always_comb begin
    sel = '0;
    unique case (space)
      SP_FIX:
        for (int k = 0; k < NUM_FIX; k++)
          if (idx == SLOT_W'(k) && fen_i[k]) sel = fix_i[k];
      SP_AUX:
        for (int k = 0; k < N_AUX; k++)
          if (idx == SLOT_W'(k) && aen_i[k]) sel = aux_i[k];
      SP_CTL: begin
        if (idx == CTL_FEN) sel[NUM_FIX-1:0] = fen_i;
        if (idx == CTL_AEN) sel[N_AUX-1:0]   = aen_i;
        if (idx == CTL_USR) sel[0]           = uen_i;
      end
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rdata_o  <= rd_go_i ? sel : '0;
      rvalid_o <= rd_go_i;
    end
  end
endmodule

// File: rtl/act_mon_bank.sv
module act_mon_bank
  import act_mon_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int N_AUX = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              retire_i,
  input  logic              stall_i,
  input  logic [N_AUX-1:0]  aux_evt_i,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [1:0]        priv_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              rvalid_o,
  output logic              trap_o
);
  logic [NUM_FIX-1:0][CNT_W-1:0] fix_q;
  logic [N_AUX-1:0][CNT_W-1:0]   aux_q;
  logic [NUM_FIX-1:0]            fen_q, fix_wr, fix_inc, fix_evt;
  logic [N_AUX-1:0]              aen_q, aux_wr, aux_inc;
  logic [NUM_CTL-1:0]            ctl_wr;
  logic                          user_en_q, trap_now, rd_go, waiting;

  assign waiting = wfi_i | wfe_i;
  assign fix_evt = {stall_i, retire_i, tick_i, 1'b1};
  assign fix_inc = fix_evt & fen_q & {NUM_FIX{~waiting}};
  assign aux_inc = aux_evt_i & aen_q & {N_AUX{~waiting}};

  act_mon_access #(.N_AUX(N_AUX)) u_access (
    .req_i, .we_i, .addr_i, .priv_i,
    .user_en_i (user_en_q),
    .trap_now_o(trap_now),
    .rd_go_o   (rd_go),
    .fix_wr_o  (fix_wr),
    .aux_wr_o  (aux_wr),
    .ctl_wr_o  (ctl_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fen_q     <= '0;
      aen_q     <= '0;
      user_en_q <= 1'b0;
      trap_o    <= 1'b0;
    end else begin
      if (ctl_wr[CTL_FEN]) fen_q     <= wdata_i[NUM_FIX-1:0];
      if (ctl_wr[CTL_AEN]) aen_q     <= wdata_i[N_AUX-1:0];
      if (ctl_wr[CTL_USR]) user_en_q <= wdata_i[0];
      trap_o <= trap_now;
    end
  end

  for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix
    act_mon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .wdata_i,
      .inc_i(fix_inc[g]), .wr_i(fix_wr[g]), .cnt_o(fix_q[g])
    );
  end
  for (genvar g = 0; g < N_AUX; g++) begin : g_aux
    act_mon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .wdata_i,
      .inc_i(aux_inc[g]), .wr_i(aux_wr[g]), .cnt_o(aux_q[g])
    );
  end

  act_mon_rdmux #(.CNT_W(CNT_W), .N_AUX(N_AUX)) u_rdmux (
    .clk_i, .rst_ni,
    .rd_go_i(rd_go), .addr_i,
    .fix_i(fix_q), .aux_i(aux_q),
    .fen_i(fen_q), .aen_i(aen_q), .uen_i(user_en_q),
    .rdata_o, .rvalid_o
  );
endmodule

// File: rtl/act_mon_bank_chk.sv
module act_mon_bank_chk
  import act_mon_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int N_AUX = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic                          we_i,
  input logic [1:0]                    priv_i,
  input logic                          wfi_i,
  input logic                          wfe_i,
  input logic                          rvalid_o,
  input logic                          trap_o,
  input logic [NUM_FIX-1:0][CNT_W-1:0] fix_q,
  input logic [N_AUX-1:0][CNT_W-1:0]   aux_q,
  input logic                          user_en_q
);
  assert_wait_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wfi_i || wfe_i) && !(req_i && we_i) |=> $stable(fix_q) && $stable(aux_q));

  assert_trap_no_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !rvalid_o);

  assert_trap_no_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && priv_i == 2'd0 && !user_en_q && (wfi_i || wfe_i)
    |=> $stable(fix_q) && $stable(aux_q) && $stable(user_en_q));

  assert_read_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> (fix_q[0] == $past(fix_q[0])) ||
                         (fix_q[0] == $past(fix_q[0]) + CNT_W'(1)));
endmodule

bind act_mon_bank act_mon_bank_chk #(.CNT_W(CNT_W), .N_AUX(N_AUX)) u_chk (.*);

// File: tb/act_mon_bank_bench.sv
`timescale 1ns/1ps
module act_mon_bank_bench;
  localparam int CNT_W = 64;
  localparam int N_AUX = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 0, retire = 0, stall = 0, wfi = 0, wfe = 0, req = 0, we = 0;
  logic [N_AUX-1:0] aux_evt = '0;
  logic [5:0] addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [1:0] priv = 2'd3;
  logic [CNT_W-1:0] rdata;
  logic rvalid, trap;

  always #2.5 clk = ~clk;

  act_mon_bank #(.CNT_W(CNT_W), .N_AUX(N_AUX)) u_act_mon_bank (
    .clk_i(clk), .rst_ni, .tick_i(tick), .retire_i(retire), .stall_i(stall),
    .aux_evt_i(aux_evt), .wfi_i(wfi), .wfe_i(wfe), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .priv_i(priv),
    .rdata_o(rdata), .rvalid_o(rvalid), .trap_o(trap)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  string cur = "R1";

  // reference model state
  longint unsigned m_fix[4];
  longint unsigned m_aux[N_AUX];
  bit [3:0] m_fen = '0;
  bit [N_AUX-1:0] m_aen = '0;
  bit m_uen = 0;
  bit e_rv; bit e_tr; longint unsigned e_rd;

  task automatic chk(bit ok, string r, longint unsigned act, longint unsigned exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic longint unsigned mread(logic [5:0] a);
    int i = int'(a[3:0]);
    case (a[5:4])
      2'd0: return (i < 4 && m_fix_en(i)) ? m_fix[i] : 0;
      2'd1: return (i < N_AUX && m_aen[i]) ? m_aux[i] : 0;
      2'd2: return i == 0 ? 64'(m_fen) : i == 1 ? 64'(m_aen) : i == 2 ? 64'(m_uen) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_fix_en(int i);
    return m_fen[i];
  endfunction

  // model update at a clock edge, using the inputs held over that edge
  task automatic model();
    bit wr_fix[4]; bit wr_aux[N_AUX]; bit gated; bit ev[4];
    int i;
    e_rv = 0; e_tr = 0; e_rd = 0;
    foreach (wr_fix[k]) wr_fix[k] = 0;
    foreach (wr_aux[k]) wr_aux[k] = 0;
    i = int'(addr[3:0]);
    if (req) begin
      if (priv == 0 && (!m_uen || addr[5:4] == 2'd2)) e_tr = 1;
      else if (!we) begin e_rv = 1; e_rd = mread(addr); end
      else begin
        if (addr[5:4] == 2'd0 && i < 4) wr_fix[i] = 1;
        if (addr[5:4] == 2'd1 && i < N_AUX) wr_aux[i] = 1;
      end
    end
    gated = wfi || wfe;
    ev = '{1'b1, tick, retire, stall};
    for (int k = 0; k < 4; k++)
      if (ev[k] && m_fen[k] && !gated && !wr_fix[k]) m_fix[k]++;
    for (int k = 0; k < N_AUX; k++)
      if (aux_evt[k] && m_aen[k] && !gated && !wr_aux[k]) m_aux[k]++;
    if (req && we && !e_tr) begin
      if (wr_fix[i]) m_fix[i] = wdata;
      if (addr[5:4] == 2'd1 && i < N_AUX) m_aux[i] = wdata;
      if (addr[5:4] == 2'd2) begin
        if (i == 0) m_fen = wdata[3:0];
        if (i == 1) m_aen = wdata[N_AUX-1:0];
        if (i == 2) m_uen = wdata[0];
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(rvalid == e_rv, cur, 64'(rvalid), 64'(e_rv));
    chk(trap == e_tr, cur, 64'(trap), 64'(e_tr));
    if (e_rv) chk(rdata == e_rd, cur, rdata, e_rd);
  endtask

  task automatic acc(bit w, logic [5:0] a, longint unsigned d, logic [1:0] p);
    req = 1; we = w; addr = a; wdata = d; priv = p;
    step();
    req = 0; we = 0;
  endtask

  task automatic run(int n, bit rnd);
    for (int c = 0; c < n; c++) begin
      if (rnd) begin
        tick = 1'($urandom); retire = 1'($urandom); stall = 1'($urandom);
        aux_evt = N_AUX'($urandom);
      end
      step();
    end
    tick = 0; retire = 0; stall = 0; aux_evt = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    foreach (m_fix[k]) m_fix[k] = 0;
    foreach (m_aux[k]) m_aux[k] = 0;
    repeat (3) @(negedge clk);
    cur = "R1";
    chk(rvalid == 0 && trap == 0, "R1", 64'({rvalid, trap}), 0);
    rst_ni = 1;
    run(3, 1);
    for (int k = 0; k < 4; k++) acc(0, 6'(k), 0, 3);
    acc(0, 6'h20, 0, 3);
    acc(0, 6'h21, 0, 3);

    cur = "R2";
    acc(1, 6'h20, 64'hF, 3);
    run(20, 1);
    for (int k = 0; k < 4; k++) acc(0, 6'(k), 0, 3);

    cur = "R3";
    acc(1, 6'h21, 64'h5, 3);
    run(20, 1);
    for (int k = 0; k < N_AUX; k++) acc(0, 6'h10 + 6'(k), 0, 3);

    cur = "R7";
    acc(0, 6'h09, 0, 3);
    acc(1, 6'h09, 64'h1234, 3);
    acc(0, 6'h09, 0, 3);
    acc(1, 6'h17, 64'h55, 3);
    acc(0, 6'h17, 0, 3);
    acc(0, 6'h25, 0, 3);
    acc(0, 6'h31, 0, 3);

    cur = "R4";
    wfi = 1; run(8, 1);
    for (int k = 0; k < 4; k++) acc(0, 6'(k), 0, 3);
    wfi = 0; wfe = 1; run(8, 1);
    acc(0, 6'h10, 0, 3);
    acc(0, 6'h02, 0, 3);
    wfe = 0;

    cur = "R5";
    acc(1, 6'h20, 64'hB, 3);
    retire = 1; run(1, 0); retire = 1; run(1, 0);
    acc(0, 6'h02, 0, 3);
    acc(1, 6'h02, 64'h77, 3);
    acc(0, 6'h11, 0, 3);
    acc(1, 6'h20, 64'hF, 3);
    acc(0, 6'h02, 0, 3);

    cur = "R8";
    acc(0, 6'h00, 0, 0);
    acc(1, 6'h01, 64'hDEAD, 0);
    acc(1, 6'h20, 64'h0, 0);
    acc(0, 6'h01, 0, 3);
    acc(0, 6'h20, 0, 3);
    acc(1, 6'h22, 64'h1, 3);
    acc(0, 6'h01, 0, 0);
    acc(0, 6'h22, 0, 0);
    acc(1, 6'h22, 64'h0, 3);

    cur = "R9";
    retire = 1; acc(1, 6'h02, 64'h1000, 3); retire = 0;
    acc(0, 6'h02, 0, 3);
    aux_evt = 4'h1; acc(1, 6'h10, 64'h200, 3); aux_evt = '0;
    acc(0, 6'h10, 0, 3);

    cur = "R10";
    acc(1, 6'h03, 64'hFFFF_FFFF_FFFF_FFFF, 3);
    stall = 1; run(1, 0);
    acc(0, 6'h03, 0, 3);
    acc(1, 6'h12, 64'hFFFF_FFFF_FFFF_FFFF, 3);
    aux_evt = 4'h4; run(1, 0);
    acc(0, 6'h12, 0, 3);

    cur = "R6";
    retire = 1;
    acc(0, 6'h02, 0, 3);
    acc(0, 6'h02, 0, 3);
    acc(0, 6'h00, 0, 3);
    retire = 0;
    run(1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule